// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Counter Stage

This block is one decade digit of a counter that can be chained with others. It holds a value from 0 to 9 and has two separate count inputs: a rising edge on the up input adds one and a rising edge on the down input subtracts one. While one count input is in use, the other one rests HIGH. Both count inputs come from outside the clock domain. Each passes through a two-flop synchronizer, and the edge is detected on the system clock.

An asynchronous clear input and an asynchronous active-low load input act on the digit register without waiting for a clock. When load is active, the value on the four data inputs appears on the output.

Two active-low terminal-count outputs, carry and borrow, repeat the waveform of the matching count input while the digit is at its end value. Each one can drive the matching count input of the next stage up. With two stages chained this way the pair counts from 00 to 99.

Top module: `bcd_updown_stage`

## Requirements
- R1: A rising edge on `up_in` with `dn_in` held HIGH raises the digit by one for values 0 to 8, and moves it from 9 to 0.
- R2: A rising edge on `dn_in` with `up_in` held HIGH lowers the digit by one for values 1 to 9, and moves it from 0 to 9.
- R3: A loaded value from 10 to 15 has a defined next state. Counting up adds one modulo 16, so 15 goes to 0. Counting down subtracts one, so 10 goes to 9.
- R4: While `clear` is HIGH, `q` is 0 at once, without waiting for a clock edge. This holds even while `load_n` is LOW, so clear has priority over load.
- R5: While `load_n` is LOW and `clear` is LOW, `q` equals `din` at once. The state of the count inputs has no effect on this.
- R6: `carry_n` is LOW exactly when `q` is 9 and the synchronized up input is LOW. `borrow_n` is LOW exactly when `q` is 0 and the synchronized down input is LOW. A count input change reaches the terminal outputs on the second clock edge and reaches `q` on the third clock edge.
- R7: If a count input is held LOW through a clear or a load, its next LOW-to-HIGH transition after release is counted.
- R8: If rising edges of both count inputs land in the same clock cycle, the digit holds its value.
- R9: When `carry_n` drives the next stage's `up_in` and `borrow_n` drives its `dn_in`, two stages count as a decimal pair from 00 to 99 in both directions, with wrap-around at both ends.
- R10: When `rst_n` is LOW at a clock edge, the digit becomes 0 and both synchronizers are set to the idle HIGH level, so releasing reset produces no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Asynchronous clear of the digit, active high |
| load_n | input | 1 | Asynchronous parallel load, active low |
| din | input | 4 | Value to load |
| up_in | input | 1 | Count-up input, counts on a rising edge |
| dn_in | input | 1 | Count-down input, counts on a rising edge |
| q | output | 4 | Current digit |
| carry_n | output | 1 | Terminal count up, active low; drives the next stage's up input |
| borrow_n | output | 1 | Terminal count down, active low; drives the next stage's down input |

## Verification
A wrong digit value shows on `q` on the third clock edge after the count input changes. It also shows in the terminal outputs: a carry or borrow pulse that is missing or extra changes the upper stage of a chained pair. That upper stage settles about three edges after the lower stage's terminal output rises. An illegal value held after a load is exposed on the next count, because the modulo-16 step it takes differs from the decade wrap. The bench therefore mixes random count and load operations with a two-stage model and compares both digits after every operation.

// File: rtl/bcd_updown_pkg.sv
// Package: shared digit type and step functions for the decimal counter stage.
// Assumes a 4-bit digit; the top of the decade is a parameter of the callers.
package bcd_updown_pkg;
    localparam int unsigned DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Next value when counting up: the top value wraps to 0, values above it step modulo 2^DIGIT_W.
    function automatic digit_t step_up(input digit_t v, input digit_t top);
        return (v == top) ? '0 : digit_t'(v + 1'b1);
    endfunction

    // Next value when counting down: 0 wraps to the top value, everything else drops by one.
    function automatic digit_t step_dn(input digit_t v, input digit_t top);
        return (v == '0) ? top : digit_t'(v - 1'b1);
    endfunction
endpackage

// File: rtl/bcd_edge_sync.sv
// Module: brings an asynchronous count input into the clock domain and flags its rising edge.
// Assumes the input rests HIGH; reset loads the idle level so that no edge is seen on release.
module bcd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            // One-flop capture of the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= raw;
            end
        end else begin : g_chain
            // Shift chain that resolves metastability on the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    // Delayed copy of the synchronized level used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/bcd_count_core.sv
// Module: the digit register with asynchronous clear and load and a clocked up/down step.
// Assumes inc and dec are single-cycle pulses; both together mean no step.
module bcd_count_core
    import bcd_updown_pkg::*;
#(
    parameter digit_t DIGIT_TOP = 4'd9
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   load_n,
    input  digit_t din,
    input  logic   inc,
    input  logic   dec,
    output digit_t q
);
    digit_t nxt;

    // Select the clocked next value from the step requests.
    always_comb begin
        unique case ({inc, dec})
            2'b10:   nxt = step_up(q, DIGIT_TOP);
            2'b01:   nxt = step_dn(q, DIGIT_TOP);
            default: nxt = q;
        endcase
    end

    // Digit register: clear over load over synchronous reset over counting.
    always_ff @(posedge clk or posedge clear or negedge load_n) begin
        if (clear)        q <= '0;
        else if (!load_n) q <= din;
        else if (!rst_n)  q <= '0;
        else              q <= nxt;
    end
endmodule

// File: rtl/bcd_tc_gen.sv
// Module: active-low terminal count outputs that follow the synchronized count inputs.
// Assumes the levels come from the synchronizers, so the outputs are glitch-free flop-driven terms.
module bcd_tc_gen
    import bcd_updown_pkg::*;
#(
    parameter digit_t DIGIT_TOP = 4'd9
) (
    input  digit_t q,
    input  logic   up_lvl,
    input  logic   dn_lvl,
    output logic   carry_n,
    output logic   borrow_n
);
    // Pass the count waveform through only at the end of the decade.
    always_comb begin
        carry_n  = ~((q == DIGIT_TOP) & ~up_lvl);
        borrow_n = ~((q == '0) & ~dn_lvl);
    end
endmodule

// File: rtl/bcd_updown_stage.sv
// Module: one cascadable decimal up/down counter stage on a single system clock.
// Assumes only one count input is active at a time and the idle one rests HIGH.
module bcd_updown_stage #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  DIGIT_TOP   = 4'd9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load_n,
    input  logic [3:0] din,
    input  logic       up_in,
    input  logic       dn_in,
    output logic [3:0] q,
    output logic       carry_n,
    output logic       borrow_n
);
    logic up_lvl, up_rise, dn_lvl, dn_rise;

    bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .raw(up_in), .level(up_lvl), .rise(up_rise)
    );

    bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .raw(dn_in), .level(dn_lvl), .rise(dn_rise)
    );

    bcd_count_core #(.DIGIT_TOP(DIGIT_TOP)) u_core (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .din(din),
        .inc(up_rise), .dec(dn_rise), .q(q)
    );

    bcd_tc_gen #(.DIGIT_TOP(DIGIT_TOP)) u_tc (
        .q(q), .up_lvl(up_lvl), .dn_lvl(dn_lvl), .carry_n(carry_n), .borrow_n(borrow_n)
    );
endmodule

// File: rtl/bcd_updown_stage_chk.sv
// Module: property checker for the counter stage, attached by bind.
// Assumes clear and load pulses are held across at least one clock edge.
module bcd_updown_stage_chk #(
    parameter logic [3:0] DIGIT_TOP = 4'd9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clear,
    input logic       load_n,
    input logic [3:0] din,
    input logic [3:0] q,
    input logic       carry_n,
    input logic       borrow_n,
    input logic       up_rise,
    input logic       dn_rise
);
    logic quiet;
    assign quiet = !clear && load_n;

    assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up_rise && !dn_rise && q == DIGIT_TOP) |=> (q == 4'd0 || clear || !load_n));

    assert_dn_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && dn_rise && !up_rise && q == 4'd0) |=> (q == DIGIT_TOP || clear || !load_n));

    assert_illegal_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up_rise && !dn_rise && q == 4'd15) |=> (q == 4'd0 || clear || !load_n));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> q == 4'd0);

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !clear) |-> q == din);

    assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> q == DIGIT_TOP);

    assert_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> q == 4'd0);

    assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up_rise && dn_rise) |=> ($stable(q) || clear || !load_n));
endmodule

bind bcd_updown_stage bcd_updown_stage_chk #(.DIGIT_TOP(DIGIT_TOP)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .din(din), .q(q),
    .carry_n(carry_n), .borrow_n(borrow_n), .up_rise(up_rise), .dn_rise(dn_rise)
);

// File: tb/test_bcd_updown_stage.sv
// Bench: two chained stages driven by directed cases and seeded random operations.
module test_bcd_updown_stage;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr0 = 1'b0, clr1 = 1'b0;
    logic       ld0_n = 1'b1, ld1_n = 1'b1;
    logic [3:0] d0 = '0, d1 = '0;
    logic       up0 = 1'b1, dn0 = 1'b1;
    logic [3:0] q0, q1;
    logic       cy0, bw0, cy1, bw1;

    int tests = 0;
    int fails = 0;
    int units = 0;
    int tens  = 0;

    always #2ns clk = ~clk;

    bcd_updown_stage i_bcd_updown_stage (
        .clk(clk), .rst_n(rst_n), .clear(clr0), .load_n(ld0_n), .din(d0),
        .up_in(up0), .dn_in(dn0), .q(q0), .carry_n(cy0), .borrow_n(bw0)
    );

    bcd_updown_stage i_bcd_updown_stage_hi (
        .clk(clk), .rst_n(rst_n), .clear(clr1), .load_n(ld1_n), .din(d1),
        .up_in(cy0), .dn_in(bw0), .q(q1), .carry_n(cy1), .borrow_n(bw1)
    );

    function automatic int f_up(input int v);
        return (v == 9) ? 0 : (v + 1) % 16;
    endfunction

    function automatic int f_dn(input int v);
        return (v == 0) ? 9 : v - 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_pair(input string tag);
        check(tag, int'(q0), units);
        check(tag, int'(q1), tens);
    endtask

    // One up pulse on the low stage; carry is checked during the low phase (R6, R9).
    task automatic pulse_up(input string tag);
        @(negedge clk) up0 = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 carry", int'(cy0), (units == 9) ? 0 : 1);
        up0 = 1'b1;
        repeat (8) @(negedge clk);
        if (units == 9) tens = f_up(tens);
        units = f_up(units);
        check_pair(tag);
    endtask

    // One down pulse on the low stage; borrow is checked during the low phase (R6, R9).
    task automatic pulse_dn(input string tag);
        @(negedge clk) dn0 = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 borrow", int'(bw0), (units == 0) ? 0 : 1);
        dn0 = 1'b1;
        repeat (8) @(negedge clk);
        if (units == 0) tens = f_dn(tens);
        units = f_dn(units);
        check_pair(tag);
    endtask

    // Asynchronous load of the low stage (R5); held over one clock edge.
    task automatic load0(input int v);
        @(negedge clk) ld0_n = 1'b0; d0 = 4'(v);
        #1ns check("R5 load", int'(q0), v);
        @(negedge clk) ld0_n = 1'b1;
        units = v;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 q0", int'(q0), 0);
        check("R10 q1", int'(q1), 0);
        check("R10 carry", int'(cy0), 1);
        check("R10 borrow", int'(bw0), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_pair("R10 no count on release");

        // R1 and R9: count through 9 into the tens digit
        for (int i = 0; i < 10; i++) pulse_up("R1 up");
        check("R9 tens", int'(q1), 1);
        // R2 and R9: borrow back down
        pulse_dn("R2 down");
        check("R9 borrow back", int'(q1), 0);
        pulse_dn("R2 down");

        // R3: illegal values
        load0(12);
        for (int i = 0; i < 4; i++) pulse_up("R3 illegal up");
        check("R3 wrap 15", int'(q0), 0);
        load0(10);
        pulse_dn("R3 illegal down");
        check("R3 10 to 9", int'(q0), 9);

        // R4: clear over load
        load0(3);
        @(negedge clk) clr0 = 1'b1; ld0_n = 1'b0; d0 = 4'd5;
        #1ns check("R4 clear priority", int'(q0), 0);
        @(negedge clk) clr0 = 1'b0; ld0_n = 1'b1;
        units = 0;
        check_pair("R4 after clear");

        // R7: count input low through a clear counts on its next rise
        @(negedge clk) up0 = 1'b0;
        repeat (4) @(negedge clk);
        clr0 = 1'b1;
        @(negedge clk) clr0 = 1'b0;
        repeat (2) @(negedge clk);
        up0 = 1'b1;
        repeat (8) @(negedge clk);
        units = 1;
        check_pair("R7 count after clear");

        // R8: both rising edges in one cycle hold the digit
        @(negedge clk) up0 = 1'b0; dn0 = 1'b0;
        repeat (4) @(negedge clk);
        up0 = 1'b1; dn0 = 1'b1;
        repeat (8) @(negedge clk);
        check_pair("R8 both edges");

        // Random operations checked against the two-digit model.
        for (int n = 0; n < 250; n++) begin
            int op;
            op = $urandom_range(0, 11);
            if (op < 6)       pulse_up("R1 random up");
            else if (op < 10) pulse_dn("R2 random down");
            else if (op == 10) begin
                load0($urandom_range(0, 15));
                check_pair("R5 random load");
            end else begin
                @(negedge clk) clr0 = 1'b1;
                #1ns check("R4 random clear", int'(q0), 0);
                @(negedge clk) clr0 = 1'b0;
                units = 0;
                check_pair("R4 random clear");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule